// File: doc/BRIEF.md
# Configurable PLD Output Cell

This block is one output cell of a programmable-logic fabric. It ORs its own product terms with any borrowed product terms from neighbouring cells that a static mask admits. An optional inversion sets the polarity of that sum. The result then either feeds a storage element or goes straight to the output. The storage element can act as a D, T, JK or SR flip-flop. Its clock is either the global fabric clock or a product-term clock. Asynchronous active-high preset and clear drive it, and a host write can load it directly.

A static mode bit picks the registered value or the combinational sum. The chosen value goes to the pin data output and to the feedback output. An output-enable product term sets whether the pad drives. The pad itself, the AND array and the input cells are outside this block. All `cfg_*` inputs are treated as static configuration and change only while the cell is held in reset.

Top module: `plc_out_cell`

## Requirements
- R1: The logic sum is the OR of all `pt_own_i` bits together with each `pt_borrow_i[i]` whose `cfg_borrow_mask_i[i]` is 1. A borrowed term with mask bit 0 has no effect.
- R2: When `cfg_invert_i` is 1, the sum is inverted. The inverted value feeds both the combinational path and the storage element.
- R3: `cfg_ff_type_i` selects the storage behaviour: 0 = D, 1 = T, 2 = JK, 3 = SR. J/S is the polarity-adjusted sum and K/R is the OR of `pt_k_i`. T toggles on 1 and holds on 0. JK gives 00 hold, 01 clear, 10 set, 11 toggle. SR gives 10 set, 01 clear, and 00 and 11 both hold.
- R4: When `cfg_comb_i` is 1, `pin_o` carries the polarity-adjusted sum. When it is 0, `pin_o` carries the flip-flop state. `fb_o` always equals `pin_o`.
- R5: When `cfg_clk_sel_i` is 0, the state updates on rising edges of `clk_i`. When it is 1, the state updates on rising edges of `pt_clk_i`. The unselected clock has no effect.
- R6: Preset (`pt_preset_i`) and clear (the OR of the bits of `pt_clear_i`) are active high and act without waiting for a clock edge. Clear wins when both are asserted.
- R7: When `host_load_i` is 1 at a selected clock edge, the state takes `host_data_i` instead of the flip-flop logic. Preset and clear still win over the load.
- R8: `pin_oe_o` follows `pt_oe_i`. While it is 0, the pad is undriven.
- R9: While `rst_ni` is low, the flip-flop state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global fabric clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pt_own_i | input | N_OWN | Native product terms |
| pt_borrow_i | input | N_BORROW | Product terms offered by neighbours |
| cfg_borrow_mask_i | input | N_BORROW | Admit mask for borrowed terms |
| pt_k_i | input | N_K | Terms forming K/R |
| pt_clk_i | input | 1 | Product-term clock |
| pt_preset_i | input | 1 | Preset term |
| pt_clear_i | input | N_CLR | Clear terms, ORed |
| pt_oe_i | input | 1 | Output-enable term |
| host_load_i | input | 1 | Host direct-load strobe |
| host_data_i | input | 1 | Host load data |
| cfg_ff_type_i | input | 2 | Storage type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_sel_i | input | 1 | 0 global clock, 1 product-term clock |
| cfg_invert_i | input | 1 | Invert the sum |
| cfg_comb_i | input | 1 | 1 combinational, 0 registered |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The bench works through all 32 combinations of storage type, clock source, polarity and output mode. In each combination it drives random terms and compares against an independent model. In product-term clock mode it pulses `pt_clk_i` on only some cycles while `clk_i` keeps running. A cell that ignored the clock select would therefore update on cycles where the model holds. Directed cases target the following:
- A borrowed term that is masked off. A broken mask turns the sum on.
- Preset and clear raised together through the second clear term. A wrong priority leaves a 1 stored.
- A host load that contradicts the logic input. A load placed below the logic keeps the logic value.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_type_e;
endpackage

// File: rtl/plc_term_sum.sv
module plc_term_sum #(
  parameter int N_OWN    = 4,
  parameter int N_BORROW = 6
) (
  input  logic [N_OWN-1:0]    own_i,
  input  logic [N_BORROW-1:0] borrow_i,
  input  logic [N_BORROW-1:0] mask_i,
  input  logic                invert_i,
  output logic                term_o
);
  logic [N_BORROW-1:0] admitted;

  for (genvar i = 0; i < N_BORROW; i++) begin : g_borrow
    assign admitted[i] = borrow_i[i] & mask_i[i];
  end

  assign term_o = ((|own_i) | (|admitted)) ^ invert_i;
endmodule

// File: rtl/plc_store.sv
module plc_store
  import plc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pt_clk_i,
  input  logic     clk_sel_i,
  input  ff_type_e type_i,
  input  logic     d_i,
  input  logic     k_i,
  input  logic     pre_i,
  input  logic     clr_i,
  input  logic     load_i,
  input  logic     load_data_i,
  output logic     q_o
);
  logic ff_clk;
  logic q_next;

  assign ff_clk = clk_sel_i ? pt_clk_i : clk_i;

  always_comb begin
    unique case (type_i)
      FF_D:  q_next = d_i;
      FF_T:  q_next = q_o ^ d_i;
      FF_JK: q_next = (d_i & k_i) ? ~q_o : (d_i ? 1'b1 : (k_i ? 1'b0 : q_o));
      FF_SR: q_next = (d_i & ~k_i) ? 1'b1 : ((k_i & ~d_i) ? 1'b0 : q_o);
      default: q_next = q_o;
    endcase
  end

  // clear over preset over host load over flip-flop logic
  always_ff @(posedge ff_clk or negedge rst_ni or posedge clr_i or posedge pre_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (pre_i)  q_o <= 1'b1;
    else if (load_i) q_o <= load_data_i;
    else             q_o <= q_next;
  end

  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && $past(clr_i)) |-> !q_o);

  p_preset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !clr_i && $past(pre_i) && !$past(clr_i)) |-> q_o);

  p_d_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_sel_i && type_i == FF_D && !clr_i && !pre_i && !load_i)
      |=> (q_o == $past(d_i) || clr_i || pre_i));

  p_t_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_sel_i && type_i == FF_T && !clr_i && !pre_i && !load_i)
      |=> (q_o == ($past(q_o) ^ $past(d_i)) || clr_i || pre_i));

  p_host_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_sel_i && load_i && !clr_i && !pre_i)
      |=> (q_o == $past(load_data_i) || clr_i || pre_i));
endmodule

// File: rtl/plc_out_cell.sv
module plc_out_cell
  import plc_pkg::*;
#(
  parameter int N_OWN    = 4,
  parameter int N_BORROW = 6,
  parameter int N_K      = 3,
  parameter int N_CLR    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_OWN-1:0]    pt_own_i,
  input  logic [N_BORROW-1:0] pt_borrow_i,
  input  logic [N_BORROW-1:0] cfg_borrow_mask_i,
  input  logic [N_K-1:0]      pt_k_i,
  input  logic                pt_clk_i,
  input  logic                pt_preset_i,
  input  logic [N_CLR-1:0]    pt_clear_i,
  input  logic                pt_oe_i,
  input  logic                host_load_i,
  input  logic                host_data_i,
  input  logic [1:0]          cfg_ff_type_i,
  input  logic                cfg_clk_sel_i,
  input  logic                cfg_invert_i,
  input  logic                cfg_comb_i,
  output logic                pin_o,
  output logic                pin_oe_o,
  output logic                fb_o
);
  logic term;
  logic q;
  logic cell_out;

  plc_term_sum #(.N_OWN(N_OWN), .N_BORROW(N_BORROW)) i_sum (
    .own_i    (pt_own_i),
    .borrow_i (pt_borrow_i),
    .mask_i   (cfg_borrow_mask_i),
    .invert_i (cfg_invert_i),
    .term_o   (term)
  );

  plc_store i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pt_clk_i    (pt_clk_i),
    .clk_sel_i   (cfg_clk_sel_i),
    .type_i      (ff_type_e'(cfg_ff_type_i)),
    .d_i         (term),
    .k_i         (|pt_k_i),
    .pre_i       (pt_preset_i),
    .clr_i       (|pt_clear_i),
    .load_i      (host_load_i),
    .load_data_i (host_data_i),
    .q_o         (q)
  );

  assign cell_out = cfg_comb_i ? term : q;
  assign pin_o    = cell_out;
  assign fb_o     = cell_out;
  assign pin_oe_o = pt_oe_i;

  p_reset_state_r9: assert property (@(posedge clk_i)
    (!rst_ni && !cfg_comb_i) |-> !pin_o);
endmodule

// File: tb/test_plc_out_cell.sv
module test_plc_out_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pt_own_i = '0;
  logic [5:0] pt_borrow_i = '0;
  logic [5:0] cfg_borrow_mask_i = '0;
  logic [2:0] pt_k_i = '0;
  logic       pt_clk_i = 1'b0;
  logic       pt_preset_i = 1'b0;
  logic [1:0] pt_clear_i = '0;
  logic       pt_oe_i = 1'b0;
  logic       host_load_i = 1'b0;
  logic       host_data_i = 1'b0;
  logic [1:0] cfg_ff_type_i = '0;
  logic       cfg_clk_sel_i = 1'b0;
  logic       cfg_invert_i = 1'b0;
  logic       cfg_comb_i = 1'b0;
  logic       pin_o, pin_oe_o, fb_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  q_m = 1'b0;
  bit  pulse = 1'b0;
  bit  done = 1'b0;

  plc_out_cell i_plc_out_cell (.*);

  always #10 clk_i = ~clk_i;

  function automatic bit model_next(int t, bit q, bit d, bit k);
    case (t)
      0: return d;
      1: return q ^ d;
      2: return (d && k) ? !q : (d ? 1'b1 : (k ? 1'b0 : q));
      default: return (d && !k) ? 1'b1 : ((k && !d) ? 1'b0 : q);
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // called at a negedge with inputs set; checks at the following negedge
  task automatic step(string tag);
    bit d_m, k_m, clr_m, edge_m, pin_m;
    string t;
    d_m    = ((|pt_own_i) | (|(pt_borrow_i & cfg_borrow_mask_i))) ^ cfg_invert_i;
    k_m    = |pt_k_i;
    clr_m  = |pt_clear_i;
    edge_m = cfg_clk_sel_i ? pulse : 1'b1;
    if (clr_m)            q_m = 1'b0;
    else if (pt_preset_i) q_m = 1'b1;
    else if (edge_m)      q_m = host_load_i ? host_data_i
                                            : model_next(int'(cfg_ff_type_i), q_m, d_m, k_m);
    t = tag;
    if (t == "") begin
      if (clr_m || pt_preset_i)        t = "R6";
      else if (host_load_i && edge_m)  t = "R7";
      else if (cfg_comb_i)             t = "R4";
      else if (cfg_clk_sel_i)          t = "R5";
      else                             t = "R3";
    end
    #5 pt_clk_i = pulse;
    #10 pt_clk_i = 1'b0;
    @(negedge clk_i);
    pin_m = cfg_comb_i ? d_m : q_m;
    check(t, pin_o, pin_m);
    check("R4 fb", fb_o, pin_m);
    check("R8 oe", pin_oe_o, pt_oe_i);
  endtask

  task automatic idle_inputs();
    pt_own_i = '0; pt_borrow_i = '0; pt_k_i = '0; pt_preset_i = 0;
    pt_clear_i = '0; host_load_i = 0; host_data_i = 0; pulse = 0; pt_oe_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle_inputs();
    @(negedge clk_i);
    rst_ni = 1'b1;
    q_m = 1'b0;
  endtask

  initial begin
    bit prev_async;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 reset pin", pin_o, 1'b0);
    check("R9 reset fb", fb_o, 1'b0);
    void'($urandom(32'h5eed_0042));

    // directed: borrow mask, polarity
    do_reset();
    cfg_comb_i = 1; cfg_ff_type_i = 0; cfg_clk_sel_i = 0; cfg_invert_i = 0;
    pt_borrow_i = 6'b000100; cfg_borrow_mask_i = 6'b111011;
    step("R1 masked borrow");
    cfg_borrow_mask_i = 6'b000100;
    step("R1 admitted borrow");
    do_reset();
    cfg_invert_i = 1;
    step("R2 inverted zero");

    // directed: clear wins via second clear term, then preset, then load
    do_reset();
    cfg_comb_i = 0; cfg_invert_i = 0; cfg_borrow_mask_i = '0;
    pt_own_i = 4'b0001; pt_preset_i = 1; pt_clear_i = 2'b10;
    step("R6 clear over preset");
    idle_inputs(); step("");
    pt_preset_i = 1;
    step("R6 preset");
    idle_inputs(); pt_own_i = 4'b1000; host_load_i = 1; host_data_i = 0;
    step("R7 load over logic");

    // directed: product-term clock, no pulse, global clock running
    do_reset();
    cfg_clk_sel_i = 1; pt_own_i = 4'b0010; pulse = 0;
    step("R5 unselected clock ignored");
    pulse = 1;
    step("R5 pt clock edge");

    // random sweep of every configuration
    for (int c = 0; c < 32; c++) begin
      do_reset();
      cfg_ff_type_i = c[1:0]; cfg_clk_sel_i = c[2];
      cfg_invert_i = c[3];    cfg_comb_i = c[4];
      cfg_borrow_mask_i = 6'($urandom);
      prev_async = 0;
      for (int n = 0; n < 30; n++) begin
        for (int b = 0; b < 4; b++) pt_own_i[b] = ($urandom % 6) == 0;
        pt_borrow_i = 6'($urandom) & 6'($urandom);
        pt_k_i      = 3'($urandom) & 3'($urandom);
        pt_oe_i     = 1'($urandom);
        host_load_i = ($urandom % 8) == 0;
        host_data_i = 1'($urandom);
        pulse       = 1'($urandom);
        if (prev_async) begin
          pt_preset_i = 0; pt_clear_i = '0;
        end else begin
          pt_preset_i = ($urandom % 14) == 0;
          pt_clear_i  = {($urandom % 24) == 0, ($urandom % 24) == 0};
        end
        prev_async = pt_preset_i | (|pt_clear_i);
        step("");
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule